// File: doc/BRIEF.md
# Bit-Serial Sample FIR Filter with Level Indicator

The block assembles 10-bit unsigned samples that arrive one bit at a time, paced by an external bit clock, while a handshake line is held high. When the handshake is released, the block places the assembled sample at the head of a tap delay line and runs one filter pass. The pass uses a single multiply-accumulate unit that visits one tap per system clock, with coefficients taken from an internal constant table. The result is a signed integer with 15 fractional bits. It is shifted right arithmetically by 15, and the scaled value sets two indicator outputs according to fixed magnitude windows.

The bit clock, handshake and data bit are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are detected in the system clock domain. A one-cycle `done` pulse marks the cycle in which the new scaled result and indicator states appear. The tap count is a parameter; its default of 8 keeps simulation short.

Top module: `serial_fir_level`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the delay line, the sample register, the fill count and the accumulator are cleared, and `y_out` = 0, `led_hi` = 0, `led_flag` = 0 and `done` = 0 afterwards.
- R2: Each rising edge of `bclk_in` seen while `hs_in` is high shifts the 10-bit sample register right by one and loads `bit_in` into bit 9. After ten such edges, the first bit sent sits in bit 0. The sample is unsigned (zero-extended).
- R3: Each falling edge of `hs_in` starts exactly one filter pass. `done` goes high for one cycle, and is observed after the TAPS+3rd rising `clk` edge following the change at the pin. No other pass runs until `hs_in` has been high again.
- R4: At the start of a pass, the delay line shifts by one and the current sample enters the head (the newest position). `y_out` is floor((sum over k of c(k)*s(k)) / 2^15), where s(0) is the oldest stored sample and s(TAPS-1) the newest. The coefficient is c(k) = -1024 when m = 0 and c(k) = 1024 + 2048*m otherwise, with m = min(k, TAPS-1-k).
- R5: Rising edges of `bclk_in` seen while `hs_in` is low leave the sample register unchanged.
- R6: If the delay line is full and 90 <= `y_out` <= 110, then `led_hi` = 1 and `led_flag` = 0.
- R7: If the delay line is full and 40 <= `y_out` <= 60, then `led_hi` = 0 and `led_flag` = 0.
- R8: For any other `y_out`, or after a pass made before TAPS samples have entered since reset, `led_hi` = 0 and `led_flag` = 1.
- R9: `y_out`, `led_hi` and `led_flag` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_in | input | 1 | Asynchronous bit clock for the serial sample |
| hs_in | input | 1 | Handshake: high while bits load; falling edge starts a pass |
| bit_in | input | 1 | Serial sample data, least significant bit first |
| y_out | output | 32 | Scaled filter output, signed |
| led_hi | output | 1 | High-window indicator |
| led_flag | output | 1 | Out-of-window or buffer-not-full indicator |
| done | output | 1 | One-cycle pulse when a new result is valid |

## Verification
The result of a pass is due after the TAPS+3rd clock edge following the handshake fall at the pin: two synchronizer stages, one start edge, and TAPS accumulate steps. The bench drops the handshake just after a falling clock edge. It then counts falling edges until `done` shows, requires that count to equal TAPS+3, and only then compares `y_out` and both indicators with its own model. After each result, the bench holds the inputs idle for a stretch of cycles. It checks that no second `done` appears and that the outputs stay where they were. Serial bits are held for several clock cycles around each bit-clock edge, so the synchronized data bit has settled before the edge is detected.

// File: rtl/serial_fir_level.sv
module serial_fir_level #(
  parameter int SAMPLE_W   = 10,
  parameter int TAPS       = 8,
  parameter int ACC_W      = 32,
  parameter int FRAC       = 15,
  parameter int HI_MIN     = 90,
  parameter int HI_MAX     = 110,
  parameter int MID_MIN    = 40,
  parameter int MID_MAX    = 60
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bclk_in,
  input  logic                    hs_in,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] y_out,
  output logic                    led_hi,
  output logic                    led_flag,
  output logic                    done
);
  localparam int IDX_W  = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int FILL_W = $clog2(TAPS + 1);
  localparam logic signed [ACC_W-1:0] HI_LO  = ACC_W'(HI_MIN);
  localparam logic signed [ACC_W-1:0] HI_UP  = ACC_W'(HI_MAX);
  localparam logic signed [ACC_W-1:0] MID_LO = ACC_W'(MID_MIN);
  localparam logic signed [ACC_W-1:0] MID_UP = ACC_W'(MID_MAX);

  function automatic logic signed [ACC_W-1:0] coef_of(input int k);
    int m;
    m = (k < TAPS - 1 - k) ? k : TAPS - 1 - k;
    if (m == 0) return ACC_W'(-1024);
    return ACC_W'(1024 + 2048 * m);
  endfunction

  logic [2:0] bclk_sy, hs_sy;
  logic [1:0] bit_sy;
  logic [SAMPLE_W-1:0] sample_q;
  logic [SAMPLE_W-1:0] taps [TAPS];
  logic [FILL_W-1:0] fill;
  logic [IDX_W-1:0] idx;
  logic busy;
  logic signed [ACC_W-1:0] acc;

  wire bclk_rise = bclk_sy[1] & ~bclk_sy[2];
  wire hs_fall   = hs_sy[2] & ~hs_sy[1];
  wire start     = hs_fall & ~busy;
  wire full      = (fill == FILL_W'(TAPS));

  logic [IDX_W-1:0] tap_sel;
  logic signed [ACC_W-1:0] tap_ext, acc_nxt, y_nxt;
  logic in_hi, in_mid;

  assign tap_sel = IDX_W'(TAPS - 1) - idx;
  assign tap_ext = ACC_W'(taps[tap_sel]);
  assign acc_nxt = acc + coef_of(int'(idx)) * tap_ext;
  assign y_nxt   = acc_nxt >>> FRAC;
  assign in_hi   = (y_nxt >= HI_LO) && (y_nxt <= HI_UP);
  assign in_mid  = (y_nxt >= MID_LO) && (y_nxt <= MID_UP);

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_sy <= '0;
      hs_sy   <= '0;
      bit_sy  <= '0;
    end else begin
      bclk_sy <= {bclk_sy[1:0], bclk_in};
      hs_sy   <= {hs_sy[1:0], hs_in};
      bit_sy  <= {bit_sy[0], bit_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sample_q <= '0;
    else if (bclk_rise && hs_sy[1])
      sample_q <= {bit_sy[1], sample_q[SAMPLE_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
      fill <= '0;
    end else if (start) begin
      taps[0] <= sample_q;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
      if (!full) fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      acc      <= '0;
      y_out    <= '0;
      led_hi   <= 1'b0;
      led_flag <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= acc_nxt;
        idx <= idx + 1'b1;
        if (idx == IDX_W'(TAPS - 1)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          y_out    <= y_nxt;
          led_hi   <= full & in_hi;
          led_flag <= ~(full & (in_hi | in_mid));
        end
      end
    end
  end
endmodule

// File: rtl/serial_fir_level_chk.sv
module serial_fir_level_chk #(
  parameter int ACC_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    done,
  input logic                    led_hi,
  input logic                    led_flag,
  input logic signed [ACC_W-1:0] y_out
);
  AST_LED_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    led_hi |-> !led_flag); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_HI_WINDOW: assert property (@(posedge clk) disable iff (rst)
    led_hi |-> (y_out >= 90 && y_out <= 110)); // R6
  AST_MID_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (done && !led_hi && !led_flag) |-> (y_out >= 40 && y_out <= 60)); // R7
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(y_out) && $stable(led_hi) && $stable(led_flag))); // R9
endmodule

bind serial_fir_level serial_fir_level_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .led_hi(led_hi),
  .led_flag(led_flag), .y_out(y_out)
);

// File: tb/serial_fir_level_test.sv
module serial_fir_level_test;
  localparam int TAPS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_in = 1'b0, hs_in = 1'b0, bit_in = 1'b0;
  logic signed [31:0] y_out;
  logic led_hi, led_flag, done;

  int nchk = 0, nfail = 0, ncyc = 0, ndone = 0;
  int hist [TAPS];
  int fillm = 0;
  int samp_m = 0;

  always #5 clk = ~clk;

  serial_fir_level uut (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .hs_in(hs_in), .bit_in(bit_in),
    .y_out(y_out), .led_hi(led_hi), .led_flag(led_flag), .done(done)
  );

  always @(posedge clk) begin
    ncyc++;
    if (done) ndone++;
    if (ncyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", ncyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic int coef_m(input int k);
    int m = (k < TAPS - 1 - k) ? k : TAPS - 1 - k;
    return (m == 0) ? -1024 : 1024 + 2048 * m;
  endfunction

  function automatic int exp_y();
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(coef_m(k)) * hist[TAPS-1-k];
    return int'(s >>> 15);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    fillm = 0;
    samp_m = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    model_reset();
    wait_cyc(2);
  endtask

  // Sends nbits bits of x (LSB first) with the handshake high, then drops it
  // and checks timing, value and indicators of the resulting pass.
  task automatic send(input int x, input int nbits);
    int n, ey, d0, ylast;
    logic full, hi, mid;
    @(negedge clk);
    hs_in = 1'b1;
    wait_cyc(4);
    for (int b = 0; b < nbits; b++) begin
      bit_in = x[b];
      wait_cyc(3);
      bclk_in = 1'b1;
      wait_cyc(4);
      bclk_in = 1'b0;
      wait_cyc(4);
      samp_m = (samp_m >> 1) | (x[b] << 9);
    end
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = samp_m;
    if (fillm < TAPS) fillm++;
    d0 = ndone;
    hs_in = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 60);
    chk("R3 done latency", n, TAPS + 3);
    ey = exp_y();
    chk("R4 filter value", y_out, ey);
    full = (fillm == TAPS);
    hi = full && ey >= 90 && ey <= 110;
    mid = full && ey >= 40 && ey <= 60;
    chk(hi ? "R6 led_hi" : "R8 led_hi", int'(led_hi), int'(hi));
    chk(mid ? "R7 led_flag" : (hi ? "R6 led_flag" : "R8 led_flag"),
        int'(led_flag), int'(!(hi || mid)));
    ylast = y_out;
    wait_cyc(20);
    chk("R3 single pass", ndone - d0, 1);
    chk("R9 y stable", y_out, ylast);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    wait_cyc(4);
    chk("R1 y_out", y_out, 0);
    chk("R1 led_hi", int'(led_hi), 0);
    chk("R1 led_flag", int'(led_flag), 0);
    chk("R1 done", int'(done), 0);
    rst = 1'b0;
    wait_cyc(2);

    // R2 / R8: in-window data while the line is still filling
    for (int i = 0; i < TAPS - 1; i++) send(114, 10);
    send(114, 10);     // R6: full, DC 114 -> 99
    send(114, 10);
    for (int i = 0; i < TAPS; i++) send(57, 10);  // R7: DC 57 -> 49
    for (int i = 0; i < TAPS; i++) send(0, 10);   // R8: zero

    // R5: bit-clock edges with handshake low are ignored
    send(683, 10);
    @(negedge clk);
    bit_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wait_cyc(3); bclk_in = 1'b1; wait_cyc(4); bclk_in = 1'b0;
    end
    send(0, 0);        // pushes the untouched sample register again (R5)

    // R10-style reset: delay line cleared, one sample then lands newest
    do_reset();
    chk("R1 y_out after reset", y_out, 0);
    chk("R1 led_flag after reset", int'(led_flag), 0);
    send(500, 10);     // -1024*500 >>> 15 = -16, not full -> R8

    // Negative result from the oldest tap
    do_reset();
    send(1023, 10);
    for (int i = 0; i < TAPS - 1; i++) send(0, 10);

    // Constrained random mix
    for (int i = 0; i < 48; i++) begin
      int r, x;
      r = int'($urandom % 4);
      case (r)
        0: x = 114;
        1: x = 57;
        2: x = int'($urandom % 1024);
        default: x = 100 + int'($urandom % 30);
      endcase
      send(x, 10);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule